// File: doc/BRIEF.md
# Dual-Port RAM with Write Inhibit

This block is a 2048-location, byte-wide memory reached through two independent ports, called left and right. Each port carries its own select, write strobe, output enable, 11-bit address, write byte, read byte and a write-inhibit (busy) input. All of it runs on one clock. Either port may read or write any location in any cycle.

The busy input of each port is driven from outside the block, in the same way that an external arbiter would drive it. While busy is low, a write from that port is dropped without any sign at the port. Tying busy low for good makes the port read-only. Tying it high gives ordinary operation.

Reads are registered. The byte appears, together with its valid flag, one cycle after the request. A port that is deselected, is writing, or has its output enable low shows valid low and a zero byte, which takes the place of a released bus. The read side is a plain valid-qualified stream with no ready input, so it cannot apply back-pressure. A requester must take each byte in the cycle it is flagged.

Top module: `dpw_ram_top`

## Requirements
- R1: While reset is applied and in the first cycle after it, both ports show read-valid low and a read byte of zero.
- R2: With select high, write strobe high and busy high at a clock edge, the port stores its write byte at its address, and either port can read that byte back later.
- R3: With select high, write strobe low and output enable high at a clock edge, the port shows read-valid high and the addressed byte after that edge.
- R4: With select low, the port neither writes nor drives data: memory is unchanged and read-valid is low after the edge, whatever the write strobe and output enable are.
- R5: With select high, write strobe low and output enable low, read-valid is low and the read byte is zero after the edge.
- R6: With busy low, a write from that port leaves memory unchanged.
- R7: If both ports write the same address at the same edge and both are allowed to write, the right port's byte is kept. If only one of them is allowed to write, that one's byte is kept.
- R8: A read of an address that the other port writes at the same edge returns the contents from before that write.
- R9: The read byte is zero whenever read-valid is low.
- R10: A write request on a port leaves that port's read-valid low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lf_sel | input | 1 | Left port select |
| lf_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| lf_oe | input | 1 | Left output enable |
| lf_busy_n | input | 1 | Left write inhibit, active low |
| lf_addr | input | 11 | Left address |
| lf_wdata | input | 8 | Left write byte |
| lf_rdata | output | 8 | Left read byte, zero when not valid |
| lf_rvalid | output | 1 | Left read byte valid |
| rt_sel | input | 1 | Right port select |
| rt_we | input | 1 | Right write strobe (1 = write, 0 = read) |
| rt_oe | input | 1 | Right output enable |
| rt_busy_n | input | 1 | Right write inhibit, active low |
| rt_addr | input | 11 | Right address |
| rt_wdata | input | 8 | Right write byte |
| rt_rdata | output | 8 | Right read byte, zero when not valid |
| rt_rvalid | output | 1 | Right read byte valid |

## Verification
Bytes are written from one port and read back from the other, using the lowest and highest addresses, so that a wrong port mapping or a wrong address decode shows up.

Attempted writes are repeated with select low and then with busy low on each side in turn. Reading back afterwards separates the two ways a write is dropped from a write that lands.

Simultaneous same-address writes are run once with both ports free and once with the right port inhibited. This separates the fixed right-wins rule from a rule that picks the port by whether it is allowed to write.

A read that collides with a write from the other port is checked against the old byte and then the new one. Reads with output enable low, and cycles spent writing, are checked to leave the valid flag low.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_READ    = 2'd1,
    OP_WRITE   = 2'd2,
    OP_BLOCKED = 2'd3
  } dpw_op_e;

  localparam int unsigned NPORTS = 2;
  localparam int unsigned PORT_LF = 0;
  localparam int unsigned PORT_RT = 1;
endpackage

// File: rtl/dpw_port_decode.sv
module dpw_port_decode
  import dpw_pkg::*;
(
  input  logic sel,
  input  logic we,
  input  logic oe,
  input  logic busy_n,
  output logic wr_go,
  output logic rd_go
);
  dpw_op_e op;

  always_comb begin
    if (!sel)     op = OP_IDLE;
    else if (we)  op = busy_n ? OP_WRITE : OP_BLOCKED;
    else if (oe)  op = OP_READ;
    else          op = OP_IDLE;
  end

  assign wr_go = (op == OP_WRITE);
  assign rd_go = (op == OP_READ);
endmodule

// File: rtl/dpw_store.sv
module dpw_store
  import dpw_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORTS-1:0]         w_go,
  input  logic [NPORTS-1:0][AW-1:0] w_addr,
  input  logic [NPORTS-1:0][DW-1:0] w_data,
  input  logic [NPORTS-1:0]         r_go,
  input  logic [NPORTS-1:0][AW-1:0] r_addr,
  output logic [NPORTS-1:0][DW-1:0] r_data,
  output logic [NPORTS-1:0]         r_vld
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Higher port index is applied last, so the right port wins a same-address tie.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORTS; p++) begin
      if (w_go[p]) mem[w_addr[p]] <= w_data[p];
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_vld[g]  <= 1'b0;
        r_data[g] <= '0;
      end else begin
        r_vld[g]  <= r_go[g];
        r_data[g] <= r_go[g] ? mem[r_addr[g]] : '0;
      end
    end
  end
endmodule

// File: rtl/dpw_ram_top.sv
module dpw_ram_top
  import dpw_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lf_sel,
  input  logic          lf_we,
  input  logic          lf_oe,
  input  logic          lf_busy_n,
  input  logic [AW-1:0] lf_addr,
  input  logic [DW-1:0] lf_wdata,
  output logic [DW-1:0] lf_rdata,
  output logic          lf_rvalid,
  input  logic          rt_sel,
  input  logic          rt_we,
  input  logic          rt_oe,
  input  logic          rt_busy_n,
  input  logic [AW-1:0] rt_addr,
  input  logic [DW-1:0] rt_wdata,
  output logic [DW-1:0] rt_rdata,
  output logic          rt_rvalid
);
  logic [NPORTS-1:0]         p_sel, p_we, p_oe, p_busy_n;
  logic [NPORTS-1:0][AW-1:0] p_addr;
  logic [NPORTS-1:0][DW-1:0] p_wdata, p_rdata;
  logic [NPORTS-1:0]         p_wr_go, p_rd_go, p_vld;

  assign p_sel    = {rt_sel, lf_sel};
  assign p_we     = {rt_we, lf_we};
  assign p_oe     = {rt_oe, lf_oe};
  assign p_busy_n = {rt_busy_n, lf_busy_n};
  assign p_addr   = {rt_addr, lf_addr};
  assign p_wdata  = {rt_wdata, lf_wdata};

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    dpw_port_decode u_dec (
      .sel    (p_sel[g]),
      .we     (p_we[g]),
      .oe     (p_oe[g]),
      .busy_n (p_busy_n[g]),
      .wr_go  (p_wr_go[g]),
      .rd_go  (p_rd_go[g])
    );
  end

  dpw_store #(.AW(AW), .DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .w_go   (p_wr_go),
    .w_addr (p_addr),
    .w_data (p_wdata),
    .r_go   (p_rd_go),
    .r_addr (p_addr),
    .r_data (p_rdata),
    .r_vld  (p_vld)
  );

  assign lf_rdata  = p_rdata[PORT_LF];
  assign lf_rvalid = p_vld[PORT_LF];
  assign rt_rdata  = p_rdata[PORT_RT];
  assign rt_rvalid = p_vld[PORT_RT];
endmodule

// File: rtl/dpw_checker.sv
module dpw_checker #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lf_sel,
  input logic          lf_we,
  input logic          lf_oe,
  input logic [DW-1:0] lf_rdata,
  input logic          lf_rvalid,
  input logic          rt_sel,
  input logic          rt_we,
  input logic          rt_oe,
  input logic [DW-1:0] rt_rdata,
  input logic          rt_rvalid
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!lf_rvalid && !rt_rvalid)); // R1

  AST_LF_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_sel && !lf_we && lf_oe) |=> lf_rvalid); // R3

  AST_RT_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_sel && !rt_we && rt_oe) |=> rt_rvalid); // R3

  AST_LF_NO_READ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(lf_sel && !lf_we && lf_oe) |=> !lf_rvalid); // R4

  AST_RT_NO_READ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(rt_sel && !rt_we && rt_oe) |=> !rt_rvalid); // R4

  AST_LF_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_sel && lf_we) |=> !lf_rvalid); // R10

  AST_RT_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_sel && rt_we) |=> !rt_rvalid); // R10

  AST_LF_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lf_rvalid |-> (lf_rdata == '0)); // R9

  AST_RT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_rvalid |-> (rt_rdata == '0)); // R9
endmodule

bind dpw_ram_top dpw_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lf_sel    (lf_sel),
  .lf_we     (lf_we),
  .lf_oe     (lf_oe),
  .lf_rdata  (lf_rdata),
  .lf_rvalid (lf_rvalid),
  .rt_sel    (rt_sel),
  .rt_we     (rt_we),
  .rt_oe     (rt_oe),
  .rt_rdata  (rt_rdata),
  .rt_rvalid (rt_rvalid)
);

// File: tb/dpw_ram_top_bench.sv
`timescale 1ns/1ps
module dpw_ram_top_bench;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lf_sel = 0, lf_we = 0, lf_oe = 0, lf_busy_n = 1;
  logic rt_sel = 0, rt_we = 0, rt_oe = 0, rt_busy_n = 1;
  logic [AW-1:0] lf_addr = '0, rt_addr = '0;
  logic [DW-1:0] lf_wdata = '0, rt_wdata = '0;
  logic [DW-1:0] lf_rdata, rt_rdata;
  logic lf_rvalid, rt_rvalid;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dpw_ram_top #(.AW(AW), .DW(DW)) u_dpw_ram_top (
    .clk(clk), .rst_n(rst_n),
    .lf_sel(lf_sel), .lf_we(lf_we), .lf_oe(lf_oe), .lf_busy_n(lf_busy_n),
    .lf_addr(lf_addr), .lf_wdata(lf_wdata), .lf_rdata(lf_rdata), .lf_rvalid(lf_rvalid),
    .rt_sel(rt_sel), .rt_we(rt_we), .rt_oe(rt_oe), .rt_busy_n(rt_busy_n),
    .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata), .rt_rvalid(rt_rvalid)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_ports();
    lf_sel = 0; lf_we = 0; lf_oe = 0; lf_busy_n = 1;
    rt_sel = 0; rt_we = 0; rt_oe = 0; rt_busy_n = 1;
  endtask

  // Inputs change on the falling edge; outputs are sampled 1 ns after the rising edge.
  task automatic step();
    @(posedge clk);
    #1;
    @(negedge clk);
  endtask

  task automatic lf_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    lf_sel = 1; lf_we = 1; lf_oe = 0; lf_addr = a; lf_wdata = d;
  endtask

  task automatic rt_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    rt_sel = 1; rt_we = 1; rt_oe = 0; rt_addr = a; rt_wdata = d;
  endtask

  task automatic lf_read(input logic [AW-1:0] a);
    lf_sel = 1; lf_we = 0; lf_oe = 1; lf_addr = a;
  endtask

  task automatic rt_read(input logic [AW-1:0] a);
    rt_sel = 1; rt_we = 0; rt_oe = 1; rt_addr = a;
  endtask

  task automatic t_reset();
    chk("R1 left in reset", {lf_rvalid, lf_rdata}, 9'h000);
    chk("R1 right in reset", {rt_rvalid, rt_rdata}, 9'h000);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 left after reset", {lf_rvalid, lf_rdata}, 9'h000);
    chk("R1 right after reset", {rt_rvalid, rt_rdata}, 9'h000);
    @(negedge clk);
  endtask

  task automatic t_write_read();
    idle_ports();
    lf_write(11'd0, 8'hA5); rt_write(11'd2047, 8'h3C);
    @(posedge clk); #1;
    chk("R10 left write no valid", {lf_rvalid, lf_rdata}, 9'h000);
    chk("R10 right write no valid", {rt_rvalid, rt_rdata}, 9'h000);
    @(negedge clk); idle_ports();
    lf_read(11'd2047); rt_read(11'd0);
    @(posedge clk); #1;
    chk("R2 R3 left reads right's byte", {lf_rvalid, lf_rdata}, {1'b1, 8'h3C});
    chk("R2 R3 right reads left's byte", {rt_rvalid, rt_rdata}, {1'b1, 8'hA5});
    @(negedge clk); idle_ports();
  endtask

  task automatic t_deselect();
    lf_sel = 0; lf_we = 1; lf_oe = 1; lf_addr = 11'd0; lf_wdata = 8'hFF;
    rt_sel = 0; rt_we = 0; rt_oe = 1; rt_addr = 11'd0;
    @(posedge clk); #1;
    chk("R4 right deselected read", {rt_rvalid, rt_rdata}, 9'h000);
    chk("R4 left deselected", {lf_rvalid, lf_rdata}, 9'h000);
    @(negedge clk); idle_ports();
    rt_read(11'd0);
    step();
    chk("R4 deselected write ignored", {rt_rvalid, rt_rdata}, {1'b1, 8'hA5});
    idle_ports();
  endtask

  task automatic t_oe_off();
    lf_sel = 1; lf_we = 0; lf_oe = 0; lf_addr = 11'd0;
    @(posedge clk); #1;
    chk("R5 R9 output enable low", {lf_rvalid, lf_rdata}, 9'h000);
    @(negedge clk); idle_ports();
  endtask

  task automatic t_busy();
    rt_write(11'd100, 8'h77);
    step(); idle_ports();
    lf_busy_n = 0; lf_write(11'd0, 8'h11);
    rt_busy_n = 0; rt_write(11'd100, 8'h22);
    step(); idle_ports();
    lf_read(11'd100); rt_read(11'd0);
    @(posedge clk); #1;
    chk("R6 right blocked write", {lf_rvalid, lf_rdata}, {1'b1, 8'h77});
    chk("R6 left blocked write", {rt_rvalid, rt_rdata}, {1'b1, 8'hA5});
    @(negedge clk); idle_ports();
  endtask

  task automatic t_collide();
    lf_write(11'd10, 8'h55); rt_write(11'd10, 8'hAA);
    step(); idle_ports();
    lf_read(11'd10);
    @(posedge clk); #1;
    chk("R7 right wins tie", {lf_rvalid, lf_rdata}, {1'b1, 8'hAA});
    @(negedge clk); idle_ports();
    lf_write(11'd10, 8'h5A); rt_busy_n = 0; rt_write(11'd10, 8'hC3);
    step(); idle_ports();
    rt_read(11'd10);
    @(posedge clk); #1;
    chk("R7 unblocked left wins", {rt_rvalid, rt_rdata}, {1'b1, 8'h5A});
    @(negedge clk); idle_ports();
  endtask

  task automatic t_read_during_write();
    lf_write(11'd20, 8'h01);
    step(); idle_ports();
    lf_write(11'd20, 8'h02); rt_read(11'd20);
    @(posedge clk); #1;
    chk("R8 old contents on collision", {rt_rvalid, rt_rdata}, {1'b1, 8'h01});
    @(negedge clk); idle_ports();
    rt_read(11'd20);
    @(posedge clk); #1;
    chk("R8 new contents afterwards", {rt_rvalid, rt_rdata}, {1'b1, 8'h02});
    @(negedge clk); idle_ports();
    step();
    chk("R9 idle right zero", {rt_rvalid, rt_rdata}, 9'h000);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_write_read();
    t_deselect();
    t_oe_off();
    t_busy();
    t_collide();
    t_read_during_write();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule